// File: doc/BRIEF.md
# Flash Address-Window Access Guard

This block stands between bus masters and a flash array and decides, for each access, whether it may proceed. It holds a bank of programmable address windows. Each window has a start address, a span, and three permission bits: an enable that turns the window on, a read grant and a write grant. An incoming access carries an address and a read/write kind. In the same cycle the guard checks whether some enabled window covers that address and allows that kind of access. A permitted access goes downstream unchanged. A refused access is consumed and dropped, and it raises a sticky violation flag that records the first offending address.

The access path is a valid/ready stream. A permitted access passes straight through: the downstream ready flows back as the upstream ready, so the guard adds no buffering and no latency. A refused access never reaches the downstream side. The guard accepts it at once, whatever the downstream ready is, so a blocked request cannot stall the bus. Software may rewrite any window register at any time, for example to open a write grant for a short interval and close it again. A register write takes effect from the clock edge that captures it.

Top module: `fwin_guard`

## Requirements
- R1: After reset every window is disabled, so every access is refused and the violation flag is low.
- R2: Register map, byte addressed on `cfg_addr`, written when `cfg_we` is high at a clock edge. Window i has its start at 8*i and its span at 8*i+4. Its permission register is at 0x40+4*i, with bit 0 = enable, bit 1 = read grant and bit 2 = write grant. The write is in force from the next cycle.
- R3: The span register holds the window length minus one, so window i covers start through start+span inclusive.
- R4: The end of a window does not wrap. If start+span exceeds the top of the address space, the window covers start up to the highest address and nothing at low addresses.
- R5: An access is permitted only when a window covers its address, has its enable set, and has the grant bit for the access kind set. A window whose enable is clear grants nothing, whatever its grant bits.
- R6: The write grant of a window can be cleared and set again at run time while its read grant stays set. Reads keep being permitted, and writes follow the write grant.
- R7: For a permitted access, `fwd_valid` equals `acc_valid`, `acc_ready` equals `fwd_ready`, and the address and kind appear unchanged at the `fwd_` outputs in the same cycle.
- R8: For a refused access, `fwd_valid` is low, `acc_ready` is high and `acc_deny` is high in the same cycle.
- R9: A refused access sets `viol_flag` from the next cycle and captures its address in `viol_addr`. Further refusals leave the captured address unchanged while the flag is set.
- R10: Pulsing `viol_clr` clears the flag at the next edge. If a refusal arrives in the same cycle as the clear, the refusal wins: the flag stays set and the new address is captured.
- R11: Overlapping windows combine: an access is permitted if any one of them permits it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | AW | Register write data |
| acc_valid | input | 1 | Upstream access valid |
| acc_ready | output | 1 | Upstream access accepted |
| acc_addr | input | AW | Access address |
| acc_write | input | 1 | Access kind, 1 = write, 0 = read |
| fwd_valid | output | 1 | Downstream access valid |
| fwd_ready | input | 1 | Downstream ready |
| fwd_addr | output | AW | Forwarded address |
| fwd_write | output | 1 | Forwarded access kind |
| acc_deny | output | 1 | Current access is refused |
| viol_flag | output | 1 | Sticky violation flag |
| viol_addr | output | AW | Address of the first refused access |
| viol_clr | input | 1 | Clears the violation flag |

## Verification
The decision path is combinational. A wrong start, span or permission bit therefore shows in the very cycle an access is presented: an address sitting just inside or just outside a window edge is forwarded when it should be blocked, or the reverse. Sweeping every address of a narrow-address build, for both access kinds, over several window layouts exposes any off-by-one at an edge, a wrapped end, or a grant that leaks from a disabled window. A fault in the violation capture appears one cycle after the refusal, as a flag that is missing, that is lost, or that holds a later address.

// File: rtl/fwin_pkg.sv
package fwin_pkg;
  // Permission bits of one window, bit 0 = enable, bit 1 = read, bit 2 = write
  typedef struct packed {
    logic wr;
    logic rd;
    logic en;
  } win_perm_t;

  localparam int CFG_AW      = 8;
  localparam int PAIR_STRIDE = 8;
  localparam int SPAN_OFS    = 4;
  localparam int PERM_REGION = 'h40;
  localparam int PERM_STRIDE = 4;
endpackage

// File: rtl/fwin_regs.sv
module fwin_regs
  import fwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AW   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [AW-1:0]                cfg_wdata,
  output logic [NWIN-1:0][AW-1:0]      win_start,
  output logic [NWIN-1:0][AW-1:0]      win_span,
  output win_perm_t [NWIN-1:0]         win_perm
);
  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam logic [CFG_AW-1:0] START_A = CFG_AW'(PAIR_STRIDE * i);
    localparam logic [CFG_AW-1:0] SPAN_A  = CFG_AW'(PAIR_STRIDE * i + SPAN_OFS);
    localparam logic [CFG_AW-1:0] PERM_A  = CFG_AW'(PERM_REGION + PERM_STRIDE * i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_start[i] <= '0;
        win_span[i]  <= '0;
        win_perm[i]  <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == START_A) win_start[i] <= cfg_wdata;
        if (cfg_addr == SPAN_A)  win_span[i]  <= cfg_wdata;
        if (cfg_addr == PERM_A)  win_perm[i]  <= win_perm_t'(cfg_wdata[2:0]);
      end
    end
  end

  // R2: a write to the first permission register lands there
  p_perm0_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == CFG_AW'(PERM_REGION) |=> win_perm[0] == win_perm_t'($past(cfg_wdata[2:0])));
  // R1: the bank leaves reset closed
  p_reset_closed_r1: assert property (@(posedge clk)
    !rst_n |=> win_perm == '0);
endmodule

// File: rtl/fwin_match.sv
module fwin_match
  import fwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AW   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [AW-1:0]                acc_addr,
  input  logic                         acc_write,
  input  logic [NWIN-1:0][AW-1:0]      win_start,
  input  logic [NWIN-1:0][AW-1:0]      win_span,
  input  win_perm_t [NWIN-1:0]         win_perm,
  output logic                         grant
);
  logic [NWIN-1:0] allow;
  logic [NWIN-1:0] en_vec;

  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    logic [AW:0] last_addr;
    logic        covered;
    logic        kind_ok;
    // one extra bit keeps the end from wrapping past the top of the space
    assign last_addr = {1'b0, win_start[i]} + {1'b0, win_span[i]};
    assign covered   = (acc_addr >= win_start[i]) && ({1'b0, acc_addr} <= last_addr);
    assign kind_ok   = acc_write ? win_perm[i].wr : win_perm[i].rd;
    assign allow[i]  = win_perm[i].en && covered && kind_ok;
    assign en_vec[i] = win_perm[i].en;
  end

  assign grant = |allow;

  // R5: nothing is granted while every window is disabled
  p_grant_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_vec == '0 |-> !grant);
endmodule

// File: rtl/fwin_viol.sv
module fwin_viol #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deny_evt,
  input  logic [AW-1:0] evt_addr,
  input  logic          clr,
  output logic          viol,
  output logic [AW-1:0] viol_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_addr <= '0;
    end else if (deny_evt && (!viol || clr)) begin
      viol      <= 1'b1;
      viol_addr <= evt_addr;
    end else if (clr) begin
      viol <= 1'b0;
    end
  end

  p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    deny_evt |=> viol);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    viol && !clr |=> viol && $stable(viol_addr));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !deny_evt |=> !viol);
endmodule

// File: rtl/fwin_guard.sv
module fwin_guard
  import fwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [AW-1:0]     acc_addr,
  input  logic              acc_write,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [AW-1:0]     fwd_addr,
  output logic              fwd_write,
  output logic              acc_deny,
  output logic              viol_flag,
  output logic [AW-1:0]     viol_addr,
  input  logic              viol_clr
);
  logic [NWIN-1:0][AW-1:0] win_start;
  logic [NWIN-1:0][AW-1:0] win_span;
  win_perm_t [NWIN-1:0]    win_perm;
  logic                    grant;

  fwin_regs #(.NWIN(NWIN), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .win_start(win_start), .win_span(win_span),
    .win_perm(win_perm)
  );

  fwin_match #(.NWIN(NWIN), .AW(AW)) u_match (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_write(acc_write),
    .win_start(win_start), .win_span(win_span), .win_perm(win_perm),
    .grant(grant)
  );

  assign acc_deny  = acc_valid && !grant;
  assign fwd_valid = acc_valid && grant;
  assign fwd_addr  = acc_addr;
  assign fwd_write = acc_write;
  // a refused access is swallowed so it never waits on the downstream side
  assign acc_ready = grant ? fwd_ready : 1'b1;

  fwin_viol #(.AW(AW)) u_viol (
    .clk(clk), .rst_n(rst_n), .deny_evt(acc_deny), .evt_addr(acc_addr),
    .clr(viol_clr), .viol(viol_flag), .viol_addr(viol_addr)
  );

  p_deny_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_deny |-> !fwd_valid && acc_ready);
  p_pass_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_deny |-> fwd_valid && (acc_ready == fwd_ready));
endmodule

// File: tb/fwin_guard_test.sv
module fwin_guard_test;
  localparam int AW   = 8;
  localparam int NWIN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic acc_valid = 1'b0, acc_write = 1'b0, fwd_ready = 1'b1, viol_clr = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic acc_ready, fwd_valid, fwd_write, acc_deny, viol_flag;
  logic [AW-1:0] fwd_addr, viol_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int m_start[NWIN];
  int m_span[NWIN];
  bit m_en[NWIN], m_rd[NWIN], m_wr[NWIN];

  always #2 clk = ~clk;

  fwin_guard #(.NWIN(NWIN), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_write(acc_write), .fwd_valid(fwd_valid),
    .fwd_ready(fwd_ready), .fwd_addr(fwd_addr), .fwd_write(fwd_write),
    .acc_deny(acc_deny), .viol_flag(viol_flag), .viol_addr(viol_addr),
    .viol_clr(viol_clr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_grant(input int a, input bit w);
    bit g = 0;
    for (int i = 0; i < NWIN; i++)
      if (m_en[i] && a >= m_start[i] && a <= m_start[i] + m_span[i] && (w ? m_wr[i] : m_rd[i]))
        g = 1;
    return g;
  endfunction

  task automatic reg_wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = AW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a >= 'h40) begin
      m_en[(a - 'h40) / 4] = d[0]; m_rd[(a - 'h40) / 4] = d[1]; m_wr[(a - 'h40) / 4] = d[2];
    end else if (a % 8 == 0) m_start[a / 8] = d;
    else m_span[a / 8] = d;
  endtask

  task automatic set_win(input int i, input int s, input int sp, input int p);
    reg_wr(8 * i, s);
    reg_wr(8 * i + 4, sp);
    reg_wr('h40 + 4 * i, p);
  endtask

  // every address, both kinds; R2 R3 R4 R5 R6 R8 R11 checked per point
  task automatic sweep(input string req);
    for (int a = 0; a < 256; a++) begin
      for (int w = 0; w < 2; w++) begin
        bit g;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = AW'(a); acc_write = w[0]; fwd_ready = 1'b1;
        #1;
        g = model_grant(a, w[0]);
        check(fwd_valid == g && acc_deny == !g && acc_ready && fwd_addr == AW'(a) && fwd_write == w[0],
              req, {fwd_valid, acc_deny}, {g, !g});
      end
    end
    @(negedge clk);
    acc_valid = 1'b0; viol_clr = 1'b1;
    @(negedge clk);
    viol_clr = 1'b0;
  endtask

  task automatic deny_at(input int a, input bit clr);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = AW'(a); acc_write = 1'b1; viol_clr = clr;
    @(negedge clk);
    acc_valid = 1'b0; viol_clr = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NWIN; i++) begin
      m_start[i] = 0; m_span[i] = 0; m_en[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(viol_flag == 1'b0, "R1 flag after reset", viol_flag, 0);
    sweep("R1 all closed");

    set_win(0, 'h10, 'h0F, 3);   // read only
    set_win(2, 'h18, 'h1F, 5);   // write only, overlaps window 0 (R11)
    set_win(3, 'h40, 'h1F, 7);
    set_win(5, 'h80, 'h0F, 6);   // grants without enable (R5)
    set_win(7, 'hF0, 'hFF, 7);   // end past top, clamped (R4)
    set_win(6, 'hA0, 'h00, 3);   // single address window (R3)
    sweep("R2 R3 R4 R5 R11 layout");

    reg_wr('h40 + 12, 3);        // R6 write grant off for window 3
    sweep("R6 write closed");
    reg_wr('h40 + 12, 7);        // R6 write grant back on
    sweep("R6 write reopened");

    // R7 back-pressure on a permitted read
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 8'h45; acc_write = 1'b0; fwd_ready = 1'b0;
    #1;
    check(fwd_valid && !acc_ready && !acc_deny && fwd_addr == 8'h45 && !fwd_write,
          "R7 stall", {fwd_valid, acc_ready}, 2'b10);
    fwd_ready = 1'b1;
    #1;
    check(fwd_valid && acc_ready, "R7 release", {fwd_valid, acc_ready}, 2'b11);
    // R8 refused write while downstream stalls is still taken
    @(negedge clk);
    acc_addr = 8'h12; acc_write = 1'b1; fwd_ready = 1'b0;
    #1;
    check(!fwd_valid && acc_ready && acc_deny, "R8 deny under stall", {fwd_valid, acc_ready}, 2'b01);
    @(negedge clk);
    acc_valid = 1'b0; fwd_ready = 1'b1; viol_clr = 1'b1;
    @(negedge clk);
    viol_clr = 1'b0;
    check(!viol_flag, "R10 clear", viol_flag, 0);

    // R9 capture and stickiness
    deny_at('h05, 0);
    check(viol_flag && viol_addr == 8'h05, "R9 capture", viol_addr, 'h05);
    deny_at('h06, 0);
    check(viol_flag && viol_addr == 8'h05, "R9 first address kept", viol_addr, 'h05);
    repeat (3) @(negedge clk);
    check(viol_flag, "R9 sticky", viol_flag, 1);
    // R10 clear with simultaneous refusal
    deny_at('h07, 1);
    check(viol_flag && viol_addr == 8'h07, "R10 refusal beats clear", viol_addr, 'h07);
    @(negedge clk);
    viol_clr = 1'b1;
    @(negedge clk);
    viol_clr = 1'b0;
    check(!viol_flag, "R10 plain clear", viol_flag, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule